// File: doc/BRIEF.md
# Pixel Clock Control and Divider

This block is the control side of a pixel-clock synthesizer. A 64-bit register, written through a single-cycle strobe and read back at any time, holds the synthesizer settings: multiplier, input divider, post divider, power-down, loop-filter capacitor enable and bypass. The same register holds software flags, an output divide-by-4, a half-rate engine mode and a pixel-domain reset bit. Reading the register also returns the synthesizer's lock indication.

The analog synthesizer is outside the block. Its output and the reference clock arrive as single-cycle tick strobes in the block's one clock domain. The block picks one of the two tick sources and can pass only every fourth selected tick. From the result it makes two clock enables. The full-rate enable serves the video output port. The engine enable serves the display and video engines; in half-rate mode it fires on every second full-rate enable. The block also drives the pixel-domain reset.

Top module: `pclk_ctrl`

## Requirements
- R1: After a chip reset the register reads 0x0000_0000_0000_0002 with lock low. The power-down output is therefore 1, and every other control output is 0.
- R2: Register layout: bit 0 is the pixel reset, bit 1 power-down, bit 2 bypass, bit 3 capacitor enable, bit 4 divide-by-4, bit 5 half-rate, bit 6 lock, bit 7 reserved, [15:8] flags, [23:16] multiplier, [31:24] input divider, [35:32] post divider and [63:36] reserved. A write stores every bit except bit 6, and reserved bits read back as written.
- R3: Bit 6 always reads the current lock input. Writing it has no effect.
- R4: With bypass set, the selected tick is the reference tick, and synthesizer ticks do not produce enables.
- R5: With bypass clear, the selected tick is the synthesizer tick, and reference ticks do not produce enables.
- R6: A 2-bit count advances on every selected tick. With divide-by-4 set, the full-rate enable fires only on a selected tick that is seen while the count is 3. With it clear, the full-rate enable fires on every selected tick.
- R7: A phase bit toggles on each full-rate enable. In half-rate mode the engine enable fires on a full-rate enable only while the phase is 1. Otherwise the engine enable equals the full-rate enable.
- R8: The pixel reset output is chip reset OR bit 0. While it is active, both enables are low. The count and the phase clear to 0 on the next clock.
- R9: Flags are cleared by chip reset only. Setting the pixel reset bit leaves them unchanged.
- R10: The multiplier, divider, power-down, capacitor and bypass outputs follow the register on the cycle after a write. This holds with or without the pixel reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| chip_rst | input | 1 | Synchronous chip soft reset, active high |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 64 | Register write data |
| rd_data | output | 64 | Register read data, including live lock |
| ref_tick | input | 1 | Reference clock tick strobe |
| pll_tick | input | 1 | Synthesizer output tick strobe |
| pll_lock | input | 1 | Lock indication from the synthesizer |
| pll_m | output | 8 | Multiplier setting |
| pll_n | output | 8 | Input divider setting |
| pll_p | output | 4 | Post divider setting |
| pll_pd | output | 1 | Synthesizer power-down, active high |
| pll_capen | output | 1 | Loop-filter capacitor enable |
| pll_bypass | output | 1 | Bypass indication to the synthesizer |
| pix_rst_o | output | 1 | Pixel-domain reset, active high |
| vop_en | output | 1 | Full-rate enable for the video output port |
| eng_en | output | 1 | Engine enable, half rate in half-rate mode |

## Verification
The assertions watch several invariants on every cycle. A register that is not written holds its value, and a write lands on the next cycle. The lock bit mirrors its input. Under bypass, no enable appears without a reference tick. Two divide-by-4 enables never come on consecutive cycles, and neither do two half-rate engine enables. The engine enable never fires without a full-rate enable. An active pixel reset silences both enables. The exact spacing and phase of the enables need the bench's scenarios to show: after a reset, across mode changes, and under random tick patterns. Flag survival across a pixel reset also rests on those scenarios.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int unsigned REG_W     = 64;
  localparam int unsigned BIT_PIXRST = 0;
  localparam int unsigned BIT_PD     = 1;
  localparam int unsigned BIT_BYP    = 2;
  localparam int unsigned BIT_CAP    = 3;
  localparam int unsigned BIT_DIV4   = 4;
  localparam int unsigned BIT_HALF   = 5;
  localparam int unsigned BIT_LOCK   = 6;
  localparam logic [REG_W-1:0] RESET_VAL = 64'h0000_0000_0000_0002;

  typedef struct packed {
    logic bypass;
    logic div4;
    logic half;
  } cond_cfg_t;

  // choose the tick source
  function automatic logic pick_tick(logic bypass, logic ref_t, logic pll_t);
    return bypass ? ref_t : pll_t;
  endfunction

  // advance the divide count on a selected tick
  function automatic logic [1:0] div_step(logic [1:0] cnt, logic tick);
    return tick ? cnt + 2'd1 : cnt;
  endfunction

  // does a selected tick pass the output divider
  function automatic logic div_pass(logic div4, logic [1:0] cnt);
    return !div4 || (cnt == 2'd3);
  endfunction

  // engine enable from full-rate enable and phase
  function automatic logic eng_pass(logic half, logic full, logic phase);
    return half ? (full && phase) : full;
  endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
(
  input  logic             clk,
  input  logic             chip_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock_in,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] LOCK_MASK = REG_W'(1) << BIT_LOCK;
  localparam logic [REG_W-1:0] WR_MASK   = ~LOCK_MASK;

  logic [REG_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data & WR_MASK;
  end

  always_ff @(posedge clk) begin
    if (chip_rst) ctrl_q <= RESET_VAL;
    else          ctrl_q <= ctrl_d;
  end

  always_comb begin
    rd_data = ctrl_q;
    rd_data[BIT_LOCK] = lock_in;
  end

  // R2: an unwritten register keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (chip_rst)
    !wr_en |=> $stable(ctrl_q));
  // R2: a write lands on the next cycle, lock excluded
  a_r2_store: assert property (@(posedge clk) disable iff (chip_rst)
    wr_en |=> (ctrl_q == ($past(wr_data) & WR_MASK)));
  // R3: read lock bit mirrors the input
  a_r3_lock_view: assert property (@(posedge clk) disable iff (chip_rst)
    rd_data[BIT_LOCK] == lock_in);
endmodule

// File: rtl/pclk_cond.sv
module pclk_cond
  import pclk_pkg::*;
(
  input  logic      clk,
  input  logic      pix_rst,
  input  cond_cfg_t cfg,
  input  logic      ref_tick,
  input  logic      pll_tick,
  output logic      sel_tick,
  output logic      full_en,
  output logic      half_en
);
  logic [1:0] cnt_q;
  logic       phase_q;
  logic       pass_hit;

  assign sel_tick = pick_tick(cfg.bypass, ref_tick, pll_tick);
  assign pass_hit = div_pass(cfg.div4, cnt_q);
  assign full_en  = !pix_rst && sel_tick && pass_hit;
  assign half_en  = !pix_rst && eng_pass(cfg.half, full_en, phase_q);

  always_ff @(posedge clk) begin
    if (pix_rst) begin
      cnt_q   <= 2'd0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= div_step(cnt_q, sel_tick);
      if (full_en) phase_q <= ~phase_q;
    end
  end

  // R4: in bypass no enable without a reference tick
  a_r4_byp_source: assert property (@(posedge clk) disable iff (pix_rst)
    (cfg.bypass && !ref_tick) |-> !full_en);
  // R6: divide-by-4 enables never on consecutive cycles
  a_r6_div4_gap: assert property (@(posedge clk) disable iff (pix_rst)
    (cfg.div4 && full_en) |=> !(cfg.div4 && full_en));
  // R7: half-rate engine enables never on consecutive cycles
  a_r7_half_gap: assert property (@(posedge clk) disable iff (pix_rst)
    (cfg.half && half_en) |=> !(cfg.half && half_en));
  // R7: engine enable only with a full-rate enable
  a_r7_subset: assert property (@(posedge clk) disable iff (pix_rst)
    half_en |-> full_en);
endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
#(
  parameter int unsigned FLAG_W = 8,
  parameter int unsigned M_W    = 8,
  parameter int unsigned N_W    = 8,
  parameter int unsigned P_W    = 4
) (
  input  logic             clk,
  input  logic             chip_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ref_tick,
  input  logic             pll_tick,
  input  logic             pll_lock,
  output logic [M_W-1:0]   pll_m,
  output logic [N_W-1:0]   pll_n,
  output logic [P_W-1:0]   pll_p,
  output logic             pll_pd,
  output logic             pll_capen,
  output logic             pll_bypass,
  output logic             pix_rst_o,
  output logic             vop_en,
  output logic             eng_en
);
  localparam int unsigned FLAG_LO = 8;
  localparam int unsigned M_LO    = FLAG_LO + FLAG_W;
  localparam int unsigned N_LO    = M_LO + M_W;
  localparam int unsigned P_LO    = N_LO + N_W;

  logic [REG_W-1:0] ctrl_q;
  cond_cfg_t        cfg;
  logic             sel_tick;

  pclk_regs u_regs (
    .clk     (clk),
    .chip_rst(chip_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .lock_in (pll_lock),
    .ctrl_q  (ctrl_q),
    .rd_data (rd_data)
  );

  assign cfg.bypass = ctrl_q[BIT_BYP];
  assign cfg.div4   = ctrl_q[BIT_DIV4];
  assign cfg.half   = ctrl_q[BIT_HALF];

  assign pll_m      = ctrl_q[M_LO +: M_W];
  assign pll_n      = ctrl_q[N_LO +: N_W];
  assign pll_p      = ctrl_q[P_LO +: P_W];
  assign pll_pd     = ctrl_q[BIT_PD];
  assign pll_capen  = ctrl_q[BIT_CAP];
  assign pll_bypass = ctrl_q[BIT_BYP];
  assign pix_rst_o  = chip_rst | ctrl_q[BIT_PIXRST];

  pclk_cond u_cond (
    .clk     (clk),
    .pix_rst (pix_rst_o),
    .cfg     (cfg),
    .ref_tick(ref_tick),
    .pll_tick(pll_tick),
    .sel_tick(sel_tick),
    .full_en (vop_en),
    .half_en (eng_en)
  );

  // R8: chip reset always drives the pixel reset
  always_comb begin
    if (chip_rst === 1'b1) a_r8_chip_hold: assert (pix_rst_o);
  end
  // R8: the register bit silences both enables
  a_r8_bit_quiet: assert property (@(posedge clk) disable iff (chip_rst)
    ctrl_q[BIT_PIXRST] |-> (pix_rst_o && !vop_en && !eng_en));
endmodule

// File: tb/pclk_ctrl_bench.sv
module pclk_ctrl_bench;
  logic        clk = 1'b0;
  logic        chip_rst, wr_en, ref_tick, pll_tick, pll_lock;
  logic [63:0] wr_data, rd_data;
  logic [7:0]  pll_m, pll_n;
  logic [3:0]  pll_p;
  logic        pll_pd, pll_capen, pll_bypass, pix_rst_o, vop_en, eng_en;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model state
  logic [63:0] m_reg;
  int          m_cnt;
  bit          m_ph;

  always #10 clk = ~clk;

  pclk_ctrl u_pclk_ctrl (
    .clk(clk), .chip_rst(chip_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ref_tick(ref_tick), .pll_tick(pll_tick),
    .pll_lock(pll_lock), .pll_m(pll_m), .pll_n(pll_n), .pll_p(pll_p),
    .pll_pd(pll_pd), .pll_capen(pll_capen), .pll_bypass(pll_bypass),
    .pix_rst_o(pix_rst_o), .vop_en(vop_en), .eng_en(eng_en)
  );

  function automatic bit exp_full();
    bit raw;
    if (chip_rst || m_reg[0]) return 1'b0;
    raw = m_reg[2] ? ref_tick : pll_tick;
    return raw && (!m_reg[4] || m_cnt == 3);
  endfunction

  function automatic bit exp_eng();
    if (!m_reg[5]) return exp_full();
    return exp_full() && m_ph;
  endfunction

  always @(posedge clk) begin
    bit f;
    f = exp_full();
    if (chip_rst) begin
      m_reg = 64'h2; m_cnt = 0; m_ph = 1'b0;
    end else begin
      if (m_reg[0]) begin
        m_cnt = 0; m_ph = 1'b0;
      end else begin
        if (m_reg[2] ? ref_tick : pll_tick) m_cnt = (m_cnt + 1) % 4;
        if (f) m_ph = !m_ph;
      end
      if (wr_en) begin
        m_reg = wr_data;
        m_reg[6] = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [63:0] er;
    er = m_reg; er[6] = pll_lock;
    chk("R2 read data", rd_data, er);
    chk("R6 vop_en", 64'(vop_en), 64'(exp_full()));
    chk("R7 eng_en", 64'(eng_en), 64'(exp_eng()));
    chk("R8 pix_rst_o", 64'(pix_rst_o), 64'(chip_rst | m_reg[0]));
    chk("R10 pll_m", 64'(pll_m), 64'(m_reg[23:16]));
    chk("R10 pll_n", 64'(pll_n), 64'(m_reg[31:24]));
    chk("R10 pll_p", 64'(pll_p), 64'(m_reg[35:32]));
    chk("R10 pll_pd", 64'(pll_pd), 64'(m_reg[1]));
    chk("R10 pll_capen", 64'(pll_capen), 64'(m_reg[3]));
    chk("R4 pll_bypass", 64'(pll_bypass), 64'(m_reg[2]));
  endtask

  task automatic step(input logic rst, input logic w, input logic [63:0] d,
                      input logic r, input logic p, input logic l);
    @(negedge clk);
    chip_rst = rst; wr_en = w; wr_data = d;
    ref_tick = r; pll_tick = p; pll_lock = l;
    #5;
    if (!done) compare_all();
  endtask

  task automatic idle(input logic r, input logic p);
    step(1'b0, 1'b0, 64'h0, r, p, pll_lock);
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(1'b0, 1'b0, 64'h0, rv[0], rv[1], rv[2]);
    end
  endtask

  task automatic wr(input logic [63:0] d);
    step(1'b0, 1'b1, d, 1'b0, 1'b0, pll_lock);
  endtask

  initial begin
    chip_rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    ref_tick = 1'b0; pll_tick = 1'b0; pll_lock = 1'b0;
    m_reg = 64'h2; m_cnt = 0; m_ph = 1'b0;
    repeat (3) step(1'b1, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0);
    idle(1'b0, 1'b0);
    chk("R1 reset value", rd_data, 64'h2);
    chk("R1 power-down after reset", 64'(pll_pd), 64'h1);

    // R3: lock bit cannot be written, reads live input
    wr(64'hFFFF_FFFF_FFFF_FFFF);
    idle(1'b0, 1'b0);
    chk("R3 lock reads low", 64'(rd_data[6]), 64'h0);
    step(1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1);
    chk("R3 lock reads high", 64'(rd_data[6]), 64'h1);
    chk("R2 reserved readback", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);

    // R10: settings with pixel reset clear
    wr(64'hABCD_EF05_1234_5608);
    idle(1'b0, 1'b0);
    chk("R10 multiplier", 64'(pll_m), 64'h34);
    chk("R10 post divider", 64'(pll_p), 64'h5);

    // R4: bypass, synthesizer tick alone gives nothing
    wr(64'h0000_0000_0000_0004);
    idle(1'b0, 1'b1);
    chk("R4 pll tick ignored in bypass", 64'(vop_en), 64'h0);
    idle(1'b1, 1'b0);
    chk("R4 ref tick drives in bypass", 64'(vop_en), 64'h1);
    run_random(60);

    // R5: normal path
    wr(64'h0000_0000_0000_0000);
    idle(1'b1, 1'b0);
    chk("R5 ref tick ignored", 64'(vop_en), 64'h0);
    idle(1'b0, 1'b1);
    chk("R5 pll tick drives", 64'(vop_en), 64'h1);

    // R6: divide-by-4 from cleared counters (via pixel reset bit)
    wr(64'h1);
    wr(64'h10);
    for (int i = 0; i < 8; i++) begin
      idle(1'b0, 1'b1);
      chk("R6 every fourth tick", 64'(vop_en), 64'((i % 4) == 3));
    end
    run_random(80);

    // R7: half-rate mode, engine at half of vop
    wr(64'h1);
    wr(64'h20);
    for (int i = 0; i < 6; i++) begin
      idle(1'b0, 1'b1);
      chk("R7 vop full rate", 64'(vop_en), 64'h1);
      chk("R7 engine half rate", 64'(eng_en), 64'(i % 2));
    end
    wr(64'h34);
    run_random(120);
    wr(64'h30);
    run_random(120);

    // R8 and R9: pixel reset keeps flags, silences enables
    wr(64'h0000_0000_0000_5A00);
    wr(64'h0000_0000_0000_5A01);
    idle(1'b0, 1'b1);
    chk("R8 enables quiet under pixel reset", 64'({vop_en, eng_en}), 64'h0);
    chk("R8 pixel reset output", 64'(pix_rst_o), 64'h1);
    chk("R9 flags kept", 64'(rd_data[15:8]), 64'h5A);
    step(1'b1, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0);
    chk("R8 chip reset drives pixel reset", 64'(pix_rst_o), 64'h1);
    idle(1'b0, 1'b0);
    chk("R9 flags cleared by chip reset", 64'(rd_data[15:8]), 64'h0);
    run_random(40);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule